// File: doc/BRIEF.md
# Cipher Word FIFO Front End

This block sits between a word-wide host path and a 64-bit block-cipher core. It holds a small control register with an engine enable, a one-shot flush request, a key-length selector and a data-ordering selector. Host words enter an input queue and are regrouped in pairs into 64-bit blocks for the core. Results from the core return as 64-bit blocks, are split into an output queue, and are read back one word at a time.

The data-ordering selector reorders every 32-bit word in the same way in both directions. Words are reordered on the way into the input queue and again on the way out of the output queue. The selector can swap the two half-words, reverse the four bytes, or reverse all 32 bits. A queue flush is honoured only while the engine is off. A key-preparation-done pulse from the core side drops the enable bit, so the host sees the engine go idle.

Top module: `cipher_word_front`

## Requirements
- R1: After reset, every control field reads 0, both queues are empty, `blk_valid` is 0 and `core_ksize` is 0.
- R2: Control bit 15 is the engine enable (1 = on). `blk_valid` is 1 only while the enable is 1 and the input queue holds two or more words.
- R3: Writing 1 to bit 14 while the enable is currently 0 empties both queues at that clock edge. Writing 0 to bit 14 does nothing.
- R4: Writing bit 14 while the enable is currently 1 leaves both queues unchanged. Bit 14 always reads back as 0.
- R5: Bits 9:8 hold the key-length code and drive `core_ksize`: 00 means 128, 01 means 192, 10 means 256, and 11 is reserved. The code is stored and read back as written.
- R6: Bits 7:6 select how each pushed word is reordered: 00 keeps it as is, 01 exchanges the upper and lower half-words, 10 reverses the byte order, and 11 reverses the bit order (bit 0 goes to bit 31).
- R7: The same reordering, chosen by the current value of bits 7:6, is applied to the word presented on `dout_data`.
- R8: The earlier of two input words forms `blk_data[63:32]` and the later one forms `blk_data[31:0]`. From a result, `res_data[63:32]` is popped first.
- R9: A `keyprep_done` pulse clears the enable bit at the next edge. This takes priority over a simultaneous register write.
- R10: Bits 31:16, 14 and 13:10 always read as 0, whatever was written.
- R11: Each queue holds 8 words and reports full and empty. A push into a full queue is ignored, and so is a pop from an empty queue.
- R12: `res_ready` is 1 only when the output queue has room for two words. A result offered without room is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| core_ksize | output | 2 | Key-length code to the core |
| keyprep_done | input | 1 | Key preparation finished, clears the enable |
| din_push | input | 1 | Push one word into the input queue |
| din_data | input | 32 | Word to push |
| din_full | output | 1 | Input queue full |
| din_empty | output | 1 | Input queue empty |
| blk_valid | output | 1 | 64-bit block available to the core |
| blk_data | output | 64 | Block to the core |
| blk_take | input | 1 | Core takes the block (removes two words) |
| res_valid | input | 1 | Core offers a 64-bit result |
| res_data | input | 64 | Result block |
| res_ready | output | 1 | Output queue has room for a result |
| dout_pop | input | 1 | Remove one word from the output queue |
| dout_data | output | 32 | Reordered head word of the output queue |
| dout_full | output | 1 | Output queue full |
| dout_empty | output | 1 | Output queue empty |

## Verification
Randomised rounds pick one of the four ordering codes and a burst of one to four word pairs. Each round checks the block presented to the core and the words returned through a pass-through core. A broken swap on either path shows up as a wrong block or as a returned word that no longer matches the original. Directed patterns keep the two paths apart. One pushes a known word under bit reversal, with a hard-coded expected value. Another changes the ordering code between push and pop, which separates the pop-side reordering from the push side. Further directed cases fill both queues past capacity, flush with the engine on and then off, and pulse key-preparation-done.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BLK_W     = 2 * WORD_W;
    localparam int unsigned EN_POS    = 15;
    localparam int unsigned FLUSH_POS = 14;
    localparam int unsigned KS_LO     = 8;
    localparam int unsigned DT_LO     = 6;

    typedef enum logic [1:0] {
        ORD_KEEP  = 2'b00,
        ORD_HALF  = 2'b01,
        ORD_BYTE  = 2'b10,
        ORD_BIT   = 2'b11
    } order_e;

    typedef struct packed {
        logic       en;
        logic [1:0] ksize;
        order_e     order;
    } ctrl_t;

    // Reorder one word; every variant is its own inverse.
    function automatic logic [WORD_W-1:0] reorder(input logic [WORD_W-1:0] w,
                                                  input order_e sel);
        logic [WORD_W-1:0] r;
        case (sel)
            ORD_HALF: r = {w[15:0], w[31:16]};
            ORD_BYTE: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            ORD_BIT: begin
                for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
            end
            default:  r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
    import cwf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              keyprep_done,
    output ctrl_t             ctrl,
    output logic              flush,
    output logic [WORD_W-1:0] rdata
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (we) begin
                ctrl_q.en    <= wdata[EN_POS];
                ctrl_q.ksize <= wdata[KS_LO+1:KS_LO];
                ctrl_q.order <= order_e'(wdata[DT_LO+1:DT_LO]);
            end
            if (keyprep_done) ctrl_q.en <= 1'b0;
        end
    end

    // Flush is gated by the enable as it stands before this write.
    assign flush = we && wdata[FLUSH_POS] && !ctrl_q.en;
    assign ctrl  = ctrl_q;

    always_comb begin
        rdata                     = '0;
        rdata[EN_POS]             = ctrl_q.en;
        rdata[KS_LO+1:KS_LO]      = ctrl_q.ksize;
        rdata[DT_LO+1:DT_LO]      = ctrl_q.order;
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:16], wdata[13:10], wdata[5:0]};

endmodule

// File: rtl/cwf_fifo.sv
// Word queue that accepts one or two words per push and releases one or
// two per pop. DEPTH must be a power of two so pointers wrap naturally.
module cwf_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       push_two,
    input  logic [W-1:0]               wd0,
    input  logic [W-1:0]               wd1,
    input  logic                       pop,
    input  logic                       pop_two,
    output logic [W-1:0]               rd0,
    output logic [W-1:0]               rd1,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       room2,
    output logic                       has2
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, n_in, n_out, free;
    logic          do_in, do_out;

    assign free   = CW'(DEPTH) - cnt;
    assign n_in   = push ? (push_two ? CW'(2) : CW'(1)) : '0;
    assign n_out  = pop  ? (pop_two  ? CW'(2) : CW'(1)) : '0;
    assign do_in  = push && (free >= n_in);
    assign do_out = pop  && (cnt  >= n_out);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_in)  wptr <= wptr + AW'(n_in);
            if (do_out) rptr <= rptr + AW'(n_out);
            cnt <= cnt + (do_in ? n_in : '0) - (do_out ? n_out : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (do_in && !flush) begin
            mem[wptr] <= wd0;
            if (push_two) mem[wptr + AW'(1)] <= wd1;
        end
    end

    assign rd0   = mem[rptr];
    assign rd1   = mem[rptr + AW'(1)];
    assign count = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign room2 = (free >= CW'(2));
    assign has2  = (cnt  >= CW'(2));

endmodule

// File: rtl/cipher_word_front.sv
module cipher_word_front
    import cwf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [1:0]  core_ksize,
    input  logic        keyprep_done,
    input  logic        din_push,
    input  logic [31:0] din_data,
    output logic        din_full,
    output logic        din_empty,
    output logic        blk_valid,
    output logic [63:0] blk_data,
    input  logic        blk_take,
    input  logic        res_valid,
    input  logic [63:0] res_data,
    output logic        res_ready,
    input  logic        dout_pop,
    output logic [31:0] dout_data,
    output logic        dout_full,
    output logic        dout_empty
);

    localparam int unsigned CW = $clog2(DEPTH+1);

    ctrl_t             ctrl;
    logic              flush;
    logic              en_q;
    logic [WORD_W-1:0] i_rd0, i_rd1, o_rd0, o_rd1;
    logic [CW-1:0]     i_count, o_count;
    logic              i_room2, i_has2, o_room2, o_has2;

    cwf_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .we           (cfg_we),
        .wdata        (cfg_wdata),
        .keyprep_done (keyprep_done),
        .ctrl         (ctrl),
        .flush        (flush),
        .rdata        (cfg_rdata)
    );

    assign en_q       = ctrl.en;
    assign core_ksize = ctrl.ksize;
    assign blk_valid  = en_q && i_has2;

    cwf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_in (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (din_push),
        .push_two (1'b0),
        .wd0      (reorder(din_data, ctrl.order)),
        .wd1      ('0),
        .pop      (blk_valid && blk_take),
        .pop_two  (1'b1),
        .rd0      (i_rd0),
        .rd1      (i_rd1),
        .count    (i_count),
        .full     (din_full),
        .empty    (din_empty),
        .room2    (i_room2),
        .has2     (i_has2)
    );

    assign blk_data = {i_rd0, i_rd1};

    cwf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (res_valid),
        .push_two (1'b1),
        .wd0      (res_data[BLK_W-1:WORD_W]),
        .wd1      (res_data[WORD_W-1:0]),
        .pop      (dout_pop),
        .pop_two  (1'b0),
        .rd0      (o_rd0),
        .rd1      (o_rd1),
        .count    (o_count),
        .full     (dout_full),
        .empty    (dout_empty),
        .room2    (o_room2),
        .has2     (o_has2)
    );

    assign res_ready = o_room2;
    assign dout_data = reorder(o_rd0, ctrl.order);

    logic unused_fifo;
    assign unused_fifo = ^{o_rd1, i_room2, o_has2};

endmodule

// File: rtl/cwf_chk.sv
module cwf_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [31:0]   cfg_wdata,
    input logic [31:0]   cfg_rdata,
    input logic          en_q,
    input logic          keyprep_done,
    input logic          blk_valid,
    input logic          din_empty,
    input logic          dout_empty,
    input logic          dout_pop,
    input logic          res_valid,
    input logic          res_ready,
    input logic [CW-1:0] i_count,
    input logic [CW-1:0] o_count
);

    assert_in_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (i_count <= CW'(DEPTH)) && (o_count <= CW'(DEPTH)));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
        (dout_pop && dout_empty && !res_valid) |=> $stable(o_count));

    assert_block_gate_R2: assert property (@(posedge clk) disable iff (rst)
        blk_valid |-> (en_q && i_count >= CW'(2)));

    assert_flush_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[14] && !en_q) |=> (din_empty && dout_empty));

    assert_keyprep_clear_R9: assert property (@(posedge clk) disable iff (rst)
        keyprep_done |=> !en_q);

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[31:16] == '0) && (cfg_rdata[13:10] == '0) && !cfg_rdata[14]);

    assert_result_drop_R12: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready && !dout_pop) |=> $stable(o_count));

endmodule

bind cipher_word_front cwf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .en_q         (en_q),
    .keyprep_done (keyprep_done),
    .blk_valid    (blk_valid),
    .din_empty    (din_empty),
    .dout_empty   (dout_empty),
    .dout_pop     (dout_pop),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .i_count      (i_count),
    .o_count      (o_count)
);

// File: tb/sim_cipher_word_front.sv
module sim_cipher_word_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  core_ksize;
    logic        keyprep_done = 1'b0;
    logic        din_push = 1'b0;
    logic [31:0] din_data = '0;
    logic        din_full, din_empty, blk_valid;
    logic [63:0] blk_data;
    logic        blk_take = 1'b0;
    logic        res_valid = 1'b0;
    logic [63:0] res_data = '0;
    logic        res_ready;
    logic        dout_pop = 1'b0;
    logic [31:0] dout_data;
    logic        dout_full, dout_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cipher_word_front u0 (.*);

    function automatic logic [31:0] ref_ord(input logic [31:0] w, input logic [1:0] t);
        logic [31:0] r;
        case (t)
            2'b01: r = {w[15:0], w[31:16]};
            2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'b11: for (int i = 0; i < 32; i++) r[i] = w[31-i];
            default: r = w;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] cfg_word(input bit en, input bit fl,
                                             input logic [1:0] ks, input logic [1:0] t);
        return {16'h0, en, fl, 4'h0, ks, t, 6'h0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); din_push = 1'b1; din_data = w;
        @(negedge clk); din_push = 1'b0;
    endtask

    // Pass-through core: take a block, return it unchanged.
    task automatic core_pass(output logic [63:0] blk);
        @(negedge clk);
        blk = blk_data; blk_take = 1'b1;
        @(negedge clk); blk_take = 1'b0; res_valid = 1'b1; res_data = blk;
        @(negedge clk); res_valid = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        @(negedge clk); w = dout_data; dout_pop = 1'b1;
        @(negedge clk); dout_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] b;
        logic [31:0] w;
        logic [31:0] words [8];
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", cfg_rdata, 0);
        check("R1 flags", {din_empty, dout_empty, blk_valid, core_ksize}, 5'b11000);

        // R10/R4/R5 readback of all-ones write; bit 14 also flushes (enable was 0)
        wr_cfg(32'hFFFF_FFFF);
        check("R10 reserved zero", cfg_rdata, 32'h0000_83C0);
        check("R5 ksize out", core_ksize, 2'b11);
        wr_cfg(cfg_word(0, 0, 2'b01, 2'b00));
        check("R5 ksize readback", cfg_rdata[9:8], 2'b01);

        // R2 gate: one word is not a block
        wr_cfg(cfg_word(1, 0, 0, 0));
        push(32'hA1A1_0001);
        check("R2 one word", blk_valid, 0);
        push(32'hA1A1_0002);
        check("R2 two words", blk_valid, 1);
        check("R8 word order", blk_data, 64'hA1A1_0001_A1A1_0002);

        // R4 flush with enable on is ignored
        wr_cfg(cfg_word(1, 1, 0, 0));
        check("R4 no flush when on", {din_empty, blk_valid}, 2'b01);
        wr_cfg(cfg_word(0, 1, 0, 0));   // enable was 1 at this write: still no flush
        check("R4 no flush same write", din_empty, 0);
        // R3 flush with enable off
        wr_cfg(cfg_word(0, 1, 0, 0));
        check("R3 flush empties", {din_empty, dout_empty}, 2'b11);

        // R6 bit reversal, hard-coded
        wr_cfg(cfg_word(0, 0, 0, 2'b11));
        push(32'h1234_5678);
        push(32'h0000_0001);
        wr_cfg(cfg_word(1, 0, 0, 2'b11));
        check("R6 bit reverse", blk_data, 64'h1E6A_2C48_8000_0000);
        core_pass(b);
        // R7 pop side alone: switch to half swap before popping
        wr_cfg(cfg_word(0, 0, 0, 2'b01));
        pop(w);
        check("R7 pop reorder", w, ref_ord(32'h1E6A_2C48, 2'b01));
        pop(w);
        check("R7 pop reorder 2nd", w, ref_ord(32'h8000_0000, 2'b01));

        // R11 overflow on input, R12 no room on output
        wr_cfg(cfg_word(0, 0, 0, 2'b10));
        for (int i = 0; i < 8; i++) begin
            words[i] = $urandom;
            push(words[i]);
        end
        check("R11 input full", din_full, 1);
        push(32'hDEAD_BEEF);
        wr_cfg(cfg_word(1, 0, 0, 2'b10));
        for (int i = 0; i < 4; i++) begin
            core_pass(b);
            check("R6 byte block", b, {ref_ord(words[2*i], 2'b10), ref_ord(words[2*i+1], 2'b10)});
        end
        check("R11 overflow dropped", {din_empty, blk_valid}, 2'b10);
        check("R12 no room", {dout_full, res_ready}, 2'b10);
        @(negedge clk); res_valid = 1'b1; res_data = 64'h0BAD_0BAD_0BAD_0BAD;
        @(negedge clk); res_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pop(w);
            check("R7 round trip", w, words[i]);
        end
        check("R12 result dropped", dout_empty, 1);
        pop(w);
        check("R11 underflow ignored", {dout_empty, res_ready}, 2'b11);

        // R9 key preparation done clears enable, beating a write
        @(negedge clk); keyprep_done = 1'b1; cfg_we = 1'b1; cfg_wdata = cfg_word(1, 0, 2'b10, 0);
        @(negedge clk); keyprep_done = 1'b0; cfg_we = 1'b0;
        check("R9 enable cleared", cfg_rdata, cfg_word(0, 0, 2'b10, 0));

        // Random rounds
        for (int r = 0; r < 24; r++) begin
            logic [1:0] t;
            logic [1:0] ks;
            int np;
            t  = 2'($urandom);
            ks = 2'($urandom_range(0, 2));
            np = $urandom_range(1, 4);
            wr_cfg(cfg_word(0, 0, ks, t));
            for (int i = 0; i < 2*np; i++) begin
                words[i] = $urandom;
                push(words[i]);
            end
            check("R2 off gate", blk_valid, 0);
            wr_cfg(cfg_word(1, 0, ks, t));
            check("R5 readback", cfg_rdata, cfg_word(1, 0, ks, t));
            for (int i = 0; i < np; i++) begin
                check("R2 ready", blk_valid, 1);
                core_pass(b);
                check("R6 R8 block", b, {ref_ord(words[2*i], t), ref_ord(words[2*i+1], t)});
            end
            for (int i = 0; i < 2*np; i++) begin
                pop(w);
                check("R7 R8 return", w, words[i]);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule